// File: doc/BRIEF.md
# Selectable Priority Interrupt Arbiter

This block collects interrupt requests from eight sources: a key-scan unit, two external pins, three timers, a watchdog and a basic interval timer. Each request is caught in a latch that holds until the source is accepted or software clears it. An enable register masks individual sources, and a master enable input gates all of them at once. The block then presents one winning source, as a valid flag and an index, to the interrupt entry sequencer that sits next to it.

A small register port holds a mode register with two parts. The 2-bit mode field picks a fixed hardware order, a software-favoured order, or total inhibition. The 4-bit code names the favoured source. In the favoured mode the named source wins whenever it competes. Otherwise the fixed order decides. The entry sequencer reports acceptance back through an acknowledge index, and that acknowledge clears the accepted source's latch.

Source indices used throughout: 0 key scan, 1 external 1, 2 external 2, 3 timer 0, 4 timer 1, 5 timer 2, 6 watchdog, 7 basic interval timer.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the mode register, the enable register and all request latches are zero, and `irq_valid_o` is 0.
- R2: Register addresses are 0 for mode, 1 for enable, 2 for the pending latches, and 3, which reads 0 and ignores writes. Mode bits 5:4 are the mode field and bits 3:0 are the favour code. Mode bits 7:6 always read 0. The enable register reads back what was written.
- R3: A high `src_req_i[i]` on a clock edge sets latch i. A set latch stays set while it is neither acknowledged nor cleared.
- R4: `ack_i` with `ack_idx_i`=k clears latch k on that edge, unless `src_req_i[k]` is high on the same edge, in which case latch k stays set.
- R5: Writing address 2 clears every latch whose data bit is 0 and leaves latches whose data bit is 1 unchanged. A write never sets a latch, and a request on the same edge survives the clear.
- R6: Source i competes only when its latch, enable bit i and `master_en_i` are all 1. With no competing source, `irq_valid_o` is 0.
- R7: In mode 00 the competing source with the lowest index wins.
- R8: In mode 01 the favour code maps to a source as follows: 0001→0, 0010→1, 0011→2, 0101→3, 0110→4, 0111→5, 1010→6, 1011→7. The mapped source wins if it competes. If it does not compete, the mode 00 order applies.
- R9: In mode 01 with an unmapped code (0000, 0100, 1000, 1001, 1100–1111), arbitration is identical to mode 00.
- R10: With mode bit 5 set (mode 10 or 11), `irq_valid_o` is 0 regardless of latches, enables and code. The latches are not affected.
- R11: `irq_idx_o` is 0 whenever `irq_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 8 | Per-source request strobes |
| master_en_i | input | 1 | Global interrupt enable flag |
| ack_i | input | 1 | Entry sequencer accepted a source |
| ack_idx_i | input | 3 | Index of the accepted source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| irq_valid_o | output | 1 | A source is being presented |
| irq_idx_o | output | 3 | Index of the presented source |

## Verification
The bench sweeps every pattern of eight pending latches under mode 00, under mode 01 with each of the sixteen codes, and under both inhibit modes. A design that decoded a favour code to the wrong source, or treated an unmapped code as a real one, would present a wrong index in these sweeps. A design that skipped the fallback when the favoured source is idle would drop a valid request. It also sweeps enable patterns against full latches and drops the master enable, which catches a source that wins while masked. Same-edge collisions of a request with an acknowledge and with a software clear are driven directly, since a design that gave the clear priority would lose an interrupt. The bench also writes ones to the pending register, which exposes a write that sets latches.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int N_SRC    = 8;
  localparam int IDX_W    = $clog2(N_SRC);
  localparam int CODE_W   = 4;
  localparam int MODE_W   = 2;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE = 2'd0,
    RA_EN   = 2'd1,
    RA_PEND = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [MODE_W-1:0] sel;
    logic [CODE_W-1:0] code;
  } mode_reg_t;

  // Favour code to source index; ok=0 for unmapped codes.
  function automatic logic [IDX_W:0] code_decode(input logic [CODE_W-1:0] c);
    logic [IDX_W:0] r;
    case (c)
      4'b0001: r = {1'b1, 3'd0};
      4'b0010: r = {1'b1, 3'd1};
      4'b0011: r = {1'b1, 3'd2};
      4'b0101: r = {1'b1, 3'd3};
      4'b0110: r = {1'b1, 3'd4};
      4'b0111: r = {1'b1, 3'd5};
      4'b1010: r = {1'b1, 3'd6};
      4'b1011: r = {1'b1, 3'd7};
      default: r = '0;
    endcase
    return r;
  endfunction

  // Lowest set bit index (fixed order, index 0 highest priority).
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output mode_reg_t         mode_q,
  output logic [N_SRC-1:0]  en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (we) begin
      if (addr == RA_MODE) mode_q <= mode_reg_t'(wdata[MODE_W+CODE_W-1:0]);
      if (addr == RA_EN)   en_q   <= wdata[N_SRC-1:0];
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_keep,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic ack_hit;
    logic clr_hit;
    assign ack_hit = ack && (ack_idx == IDX_W'(g));
    assign clr_hit = clr_we && !clr_keep[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= req[g] | (pend_q[g] & ~ack_hit & ~clr_hit);
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
(
  input  mode_reg_t        mode,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] en,
  input  logic             master,
  output logic [N_SRC-1:0] compete,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W:0]   fav;
  logic             fav_wins;
  logic [IDX_W-1:0] fixed_idx;
  logic             inhibit;

  assign compete   = pend & en & {N_SRC{master}};
  assign inhibit   = mode.sel[1];
  assign fav       = code_decode(mode.code);
  assign fixed_idx = lowest_set(compete);
  assign fav_wins  = (mode.sel == 2'b01) && fav[IDX_W] && compete[fav[IDX_W-1:0]];

  always_comb begin
    valid = !inhibit && (compete != '0);
    idx   = '0;
    if (valid) idx = fav_wins ? fav[IDX_W-1:0] : fixed_idx;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req_i,
  input  logic              master_en_i,
  input  logic              ack_i,
  input  logic [IDX_W-1:0]  ack_idx_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_valid_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  mode_reg_t        mode_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] compete_w;
  logic             pend_clr_w;

  assign pend_clr_w = reg_we_i && (reg_addr_i == RA_PEND);

  irq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .mode_q(mode_q), .en_q(en_q)
  );

  irq_req_latch u_lat (
    .clk(clk), .rst_n(rst_n), .req(src_req_i), .ack(ack_i),
    .ack_idx(ack_idx_i), .clr_we(pend_clr_w), .clr_keep(reg_wdata_i[N_SRC-1:0]),
    .pend_q(pend_q)
  );

  irq_pick u_pick (
    .mode(mode_q), .pend(pend_q), .en(en_q), .master(master_en_i),
    .compete(compete_w), .valid(irq_valid_o), .idx(irq_idx_o)
  );

  always_comb begin
    case (reg_addr_i)
      RA_MODE: reg_rdata_o = DATA_W'(mode_q);
      RA_EN:   reg_rdata_o = DATA_W'(en_q);
      RA_PEND: reg_rdata_o = DATA_W'(pend_q);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_req_i,
  input logic             master_en_i,
  input logic             ack_i,
  input logic [IDX_W-1:0] ack_idx_i,
  input mode_reg_t        mode_q,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] pend_q,
  input logic             irq_valid_o,
  input logic [IDX_W-1:0] irq_idx_o
);
  a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.sel[1] |-> !irq_valid_o);

  a_r6_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> master_en_i);

  a_r6_winner_armed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (en_q[irq_idx_o] && pend_q[irq_idx_o]));

  a_r11_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid_o |-> (irq_idx_o == '0));

  a_r3_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req_i != '0) |=> ((pend_q & $past(src_req_i)) == $past(src_req_i)));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !src_req_i[ack_idx_i]) |=> !pend_q[$past(ack_idx_i)]);

  a_r7_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && mode_q.sel == 2'b00) |->
      ((pend_q & en_q & ((8'd1 << irq_idx_o) - 8'd1)) == '0));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .master_en_i(master_en_i),
  .ack_i(ack_i), .ack_idx_i(ack_idx_i), .mode_q(mode_q), .en_q(en_q),
  .pend_q(pend_q), .irq_valid_o(irq_valid_o), .irq_idx_o(irq_idx_o)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] src_req = 0;
  logic       master = 0;
  logic       ack = 0;
  logic [2:0] ack_idx = 0;
  logic       we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       valid;
  logic [2:0] idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .master_en_i(master),
    .ack_i(ack), .ack_idx_i(ack_idx), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_valid_o(valid), .irq_idx_o(idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step();
    we = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    addr = a; #1;
    chk(rdata == exp[7:0], req, "register read", rdata, exp);
  endtask

  task automatic load_pend(input logic [7:0] m);
    wr(2'd2, 8'h00);
    src_req = m;
    step();
    src_req = 0;
  endtask

  // Source index to favour code, written arithmetically.
  function automatic int code_of(input int i);
    if (i < 3) return i + 1;
    if (i < 6) return i + 2;
    return i + 4;
  endfunction

  function automatic void model(input int mode, input int code, input logic [7:0] pend,
                                input logic [7:0] en, input bit mst,
                                output bit v, output int ix);
    logic [7:0] comp;
    int fav;
    comp = pend & en & {8{mst}};
    v = 0; ix = 0;
    if (mode >= 2 || comp == 0) return;
    v = 1;
    fav = -1;
    if (mode == 1)
      for (int j = 0; j < 8; j++) if (code_of(j) == code) fav = j;
    if (fav >= 0 && comp[fav]) begin ix = fav; return; end
    for (int j = 7; j >= 0; j--) if (comp[j]) ix = j;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ev; int ei;
    repeat (2) step();
    // R1 reset state
    chk(valid == 0, "R1", "valid after reset", valid, 0);
    rd_chk(2'd0, 0, "R1");
    rd_chk(2'd1, 0, "R1");
    rd_chk(2'd2, 0, "R1");
    rst_n = 1;
    step();
    // R2 register map
    wr(2'd0, 8'hFF); rd_chk(2'd0, 8'h3F, "R2");
    wr(2'd1, 8'hA5); rd_chk(2'd1, 8'hA5, "R2");
    wr(2'd3, 8'hFF); rd_chk(2'd3, 0, "R2");
    rd_chk(2'd1, 8'hA5, "R2");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    master = 1;
    // R3 latch set and hold
    src_req = 8'h10; step(); src_req = 0;
    repeat (5) step();
    rd_chk(2'd2, 8'h10, "R3");
    chk(valid && idx == 4, "R3", "held request presented", idx, 4);
    // R4 ack clears, same-edge request kept
    load_pend(8'hFF);
    ack = 1; ack_idx = 3; src_req = 8'h08; step(); ack = 0; src_req = 0;
    rd_chk(2'd2, 8'hFF, "R4");
    ack = 1; ack_idx = 3; step(); ack = 0;
    rd_chk(2'd2, 8'hF7, "R4");
    ack = 1; ack_idx = 0; step(); ack = 0;
    chk(idx == 1, "R4", "next source after ack", idx, 1);
    // R5 software clear
    load_pend(8'hFF);
    wr(2'd2, 8'hF0); rd_chk(2'd2, 8'hF0, "R5");
    wr(2'd2, 8'hFF); rd_chk(2'd2, 8'hF0, "R5");
    src_req = 8'h01; wr(2'd2, 8'h00); src_req = 0;
    rd_chk(2'd2, 8'h01, "R5");
    // R6 master enable and enable sweep
    load_pend(8'hFF);
    master = 0; #1;
    chk(valid == 0, "R6", "master off valid", valid, 0);
    chk(idx == 0, "R11", "idle index", idx, 0);
    master = 1;
    for (int e = 0; e < 256; e++) begin
      wr(2'd1, 8'(e));
      model(0, 0, 8'hFF, 8'(e), 1, ev, ei);
      chk(valid == ev, "R6", "valid vs enable", valid, ev);
      chk(idx == 3'(ei), "R6", "index vs enable", idx, ei);
    end
    wr(2'd1, 8'hFF);
    // R7..R10 sweep: mode 00, mode 01 with all codes, modes 10 and 11
    for (int m = 0; m < 19; m++) begin
      int mode; int code;
      mode = (m == 0) ? 0 : (m <= 16) ? 1 : m - 15;
      code = (m >= 1 && m <= 16) ? m - 1 : 4'hB;
      wr(2'd0, 8'((mode << 4) | code));
      for (int p = 0; p < 256; p++) begin
        string tag;
        bit mapped;
        load_pend(8'(p));
        model(mode, code, 8'(p), 8'hFF, 1, ev, ei);
        mapped = 0;
        for (int j = 0; j < 8; j++) if (code_of(j) == code) mapped = 1;
        tag = (mode == 0) ? "R7" : (mode == 1) ? (mapped ? "R8" : "R9") : "R10";
        chk(valid == ev, tag, "valid", valid, ev);
        chk(idx == 3'(ei), ev ? tag : "R11", "index", idx, ei);
      end
    end
    // R10 latches untouched by inhibit
    load_pend(8'h5A);
    rd_chk(2'd2, 8'h5A, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule